// File: doc/BRIEF.md
# Operand Stagger and Result Coalesce Bypass

This block is the forwarding network that sits around an arithmetic unit built from two 16-bit slices working one cycle apart. An operation enters with two source register tags and the full-width values read for them. Each value comes from the register file or from a long-latency unit such as a shifter or multiplier. The low halves of both operands leave in the same cycle. The high halves leave one cycle later. In each half, a value still in flight in the fast cluster replaces the stored value.

Results come back from the unit as separate halves, each with its destination tag. The low half comes first and the high half follows one cycle later. Both halves are kept in short age-ordered windows. A dependent operation therefore picks up each half directly, and the word is never rebuilt between fast operations. The word is rebuilt only when it leaves the cluster. A high half whose tag equals the low half captured one cycle earlier is joined to it. The full word then appears on the write-back port one cycle later, marked for the register file or for a long-latency unit.

Top module: `stagger_bypass`

## Requirements
- R1: In the cycle of a request, `op_a_lo`/`op_b_lo` carry bits [15:0] of the newest in-flight low result whose tag equals the source tag. If no in-flight low result has that tag, they carry bits [15:0] of the entry value.
- R2: The entry value of source A is `lat_data` when `a_sel_lat` is 1 and `rf_a_data` when it is 0. Source B uses `b_sel_lat` and `rf_b_data` in the same way. Both halves of a source with no forwarding match come from this value.
- R3: `op_hi_valid` is high exactly one cycle after `req_valid`. In that cycle, `op_a_hi`/`op_b_hi` carry the newest in-flight high result matching the tag sampled with the request. The high-half match is made in that later cycle. If nothing matches, they carry bits [31:16] of the entry value.
- R4: The newest matching result wins. A result presented at the input in the current cycle beats every stored one, and among stored results the youngest wins.
- R5: A result half is in flight in the cycle it is presented and for DEPTH (default 4) cycles after. It is not forwarded after that.
- R6: A high result arrives in cycle H with tag T, and the low result captured in cycle H-1 also has tag T. Then in cycle H+1, `wb_valid` is 1, `wb_tag` is T and `wb_data` is {high half, low half}.
- R7: No write-back is produced from a high half that has no matching low half in the previous cycle. No write-back is produced from a low half that is never followed by its high half.
- R8: `wb_to_lat` repeats the route flag `res_lo_to_lat` that came with the low half of the coalesced word. A value of 1 means the word goes to a long-latency unit.
- R9: After reset, both windows are empty and `op_hi_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request present |
| req_a_tag | input | 5 | Source A register tag |
| req_b_tag | input | 5 | Source B register tag |
| rf_a_data | input | 32 | Register file value for source A |
| rf_b_data | input | 32 | Register file value for source B |
| lat_data | input | 32 | Long-latency unit output value |
| a_sel_lat | input | 1 | Source A entry value from long-latency unit |
| b_sel_lat | input | 1 | Source B entry value from long-latency unit |
| op_a_lo | output | 16 | Source A low half, request cycle |
| op_b_lo | output | 16 | Source B low half, request cycle |
| op_hi_valid | output | 1 | High operand halves valid |
| op_a_hi | output | 16 | Source A high half, one cycle later |
| op_b_hi | output | 16 | Source B high half, one cycle later |
| res_lo_valid | input | 1 | Low result half present |
| res_lo_tag | input | 5 | Destination tag of low result |
| res_lo_data | input | 16 | Low result half |
| res_lo_to_lat | input | 1 | Route flag for the coalesced word |
| res_hi_valid | input | 1 | High result half present |
| res_hi_tag | input | 5 | Destination tag of high result |
| res_hi_data | input | 16 | High result half |
| wb_valid | output | 1 | Coalesced word valid |
| wb_tag | output | 5 | Coalesced word destination tag |
| wb_data | output | 32 | Coalesced full word |
| wb_to_lat | output | 1 | Coalesced word goes to a long-latency unit |

## Verification
The assertions take it for granted that the unit behind the block delivers the high half of each result one cycle after its low half. They also assume that a value which has left both windows is already visible in the entry value. They do not rely on the tag sequence. The bench draws tags from a small set so that matches, multiple matches and priority conflicts are frequent. The high result tag usually repeats the previous low tag, and sometimes differs or arrives without a low half, so that both the pairing and the refusal paths occur.

// File: rtl/stagger_bypass.sv
module stagger_bypass #(
  parameter int W     = 32,
  parameter int TAGW  = 5,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [TAGW-1:0] req_a_tag,
  input  logic [TAGW-1:0] req_b_tag,
  input  logic [W-1:0]    rf_a_data,
  input  logic [W-1:0]    rf_b_data,
  input  logic [W-1:0]    lat_data,
  input  logic            a_sel_lat,
  input  logic            b_sel_lat,
  output logic [W/2-1:0]  op_a_lo,
  output logic [W/2-1:0]  op_b_lo,
  output logic            op_hi_valid,
  output logic [W/2-1:0]  op_a_hi,
  output logic [W/2-1:0]  op_b_hi,
  input  logic            res_lo_valid,
  input  logic [TAGW-1:0] res_lo_tag,
  input  logic [W/2-1:0]  res_lo_data,
  input  logic            res_lo_to_lat,
  input  logic            res_hi_valid,
  input  logic [TAGW-1:0] res_hi_tag,
  input  logic [W/2-1:0]  res_hi_data,
  output logic            wb_valid,
  output logic [TAGW-1:0] wb_tag,
  output logic [W-1:0]    wb_data,
  output logic            wb_to_lat
);
  localparam int H = W / 2;

  logic [DEPTH-1:0] lo_v, lo_r, hi_v;
  logic [TAGW-1:0]  lo_t [DEPTH];
  logic [H-1:0]     lo_d [DEPTH];
  logic [TAGW-1:0]  hi_t [DEPTH];
  logic [H-1:0]     hi_d [DEPTH];

  logic [TAGW-1:0]  q_ta, q_tb;
  logic [H-1:0]     q_ha, q_hb;

  logic [W-1:0] ent_a, ent_b;
  logic         pair;

  assign ent_a = a_sel_lat ? lat_data : rf_a_data;
  assign ent_b = b_sel_lat ? lat_data : rf_b_data;
  assign pair  = res_hi_valid && lo_v[0] && (lo_t[0] == res_hi_tag);

  always_comb begin
    op_a_lo = ent_a[H-1:0];
    op_b_lo = ent_b[H-1:0];
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (lo_v[i] && lo_t[i] == req_a_tag) op_a_lo = lo_d[i];
      if (lo_v[i] && lo_t[i] == req_b_tag) op_b_lo = lo_d[i];
    end
    if (res_lo_valid && res_lo_tag == req_a_tag) op_a_lo = res_lo_data;
    if (res_lo_valid && res_lo_tag == req_b_tag) op_b_lo = res_lo_data;
  end

  always_comb begin
    op_a_hi = q_ha;
    op_b_hi = q_hb;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (hi_v[i] && hi_t[i] == q_ta) op_a_hi = hi_d[i];
      if (hi_v[i] && hi_t[i] == q_tb) op_b_hi = hi_d[i];
    end
    if (res_hi_valid && res_hi_tag == q_ta) op_a_hi = res_hi_data;
    if (res_hi_valid && res_hi_tag == q_tb) op_b_hi = res_hi_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_v <= '0;
      lo_r <= '0;
      hi_v <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lo_t[i] <= '0;
        lo_d[i] <= '0;
        hi_t[i] <= '0;
        hi_d[i] <= '0;
      end
    end else begin
      lo_v <= {lo_v[DEPTH-2:0], res_lo_valid};
      lo_r <= {lo_r[DEPTH-2:0], res_lo_to_lat};
      hi_v <= {hi_v[DEPTH-2:0], res_hi_valid};
      for (int i = 1; i < DEPTH; i++) begin
        lo_t[i] <= lo_t[i-1];
        lo_d[i] <= lo_d[i-1];
        hi_t[i] <= hi_t[i-1];
        hi_d[i] <= hi_d[i-1];
      end
      lo_t[0] <= res_lo_tag;
      lo_d[0] <= res_lo_data;
      hi_t[0] <= res_hi_tag;
      hi_d[0] <= res_hi_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_hi_valid <= 1'b0;
      q_ta        <= '0;
      q_tb        <= '0;
      q_ha        <= '0;
      q_hb        <= '0;
    end else begin
      op_hi_valid <= req_valid;
      q_ta        <= req_a_tag;
      q_tb        <= req_b_tag;
      q_ha        <= ent_a[W-1:H];
      q_hb        <= ent_b[W-1:H];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_tag    <= '0;
      wb_data   <= '0;
      wb_to_lat <= 1'b0;
    end else begin
      wb_valid  <= pair;
      wb_tag    <= res_hi_tag;
      wb_data   <= {res_hi_data, lo_d[0]};
      wb_to_lat <= lo_r[0];
    end
  end

  a_r6_wb_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[W-1:H] == $past(res_hi_data)) && (wb_tag == $past(res_hi_tag)));

  a_r6_wb_lower: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(res_lo_valid, 2) && (wb_data[H-1:0] == $past(res_lo_data, 2))
                 && ($past(res_lo_tag, 2) == wb_tag));

  a_r7_wb_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(res_hi_valid));

  a_r8_route_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_to_lat == $past(res_lo_to_lat, 2)));

  a_r4_lo_current_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_lo_valid && res_lo_tag == req_a_tag) |-> (op_a_lo == res_lo_data));

  a_r3_hi_current_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hi_valid && res_hi_valid && res_hi_tag == $past(req_b_tag)) |-> (op_b_hi == res_hi_data));

  a_r3_hi_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_hi_valid) |-> $past(req_valid));
endmodule

// File: tb/tb_stagger_bypass.sv
module tb_stagger_bypass;
  localparam int W = 32, TAGW = 5, DEPTH = 4, H = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid, a_sel_lat, b_sel_lat;
  logic [TAGW-1:0] req_a_tag, req_b_tag;
  logic [W-1:0] rf_a_data, rf_b_data, lat_data;
  logic [H-1:0] op_a_lo, op_b_lo, op_a_hi, op_b_hi;
  logic op_hi_valid;
  logic res_lo_valid, res_lo_to_lat, res_hi_valid;
  logic [TAGW-1:0] res_lo_tag, res_hi_tag;
  logic [H-1:0] res_lo_data, res_hi_data;
  logic wb_valid, wb_to_lat;
  logic [TAGW-1:0] wb_tag;
  logic [W-1:0] wb_data;

  always #2 clk = ~clk;

  stagger_bypass #(.W(W), .TAGW(TAGW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a_tag(req_a_tag), .req_b_tag(req_b_tag),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .lat_data(lat_data),
    .a_sel_lat(a_sel_lat), .b_sel_lat(b_sel_lat),
    .op_a_lo(op_a_lo), .op_b_lo(op_b_lo), .op_hi_valid(op_hi_valid),
    .op_a_hi(op_a_hi), .op_b_hi(op_b_hi),
    .res_lo_valid(res_lo_valid), .res_lo_tag(res_lo_tag), .res_lo_data(res_lo_data),
    .res_lo_to_lat(res_lo_to_lat), .res_hi_valid(res_hi_valid), .res_hi_tag(res_hi_tag),
    .res_hi_data(res_hi_data), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_to_lat(wb_to_lat));

  int n_cmp = 0, n_bad = 0;
  string lbl_lo = "R1", lbl_hi = "R3";

  logic            m_lo_v [DEPTH], m_lo_r [DEPTH], m_hi_v [DEPTH];
  logic [TAGW-1:0] m_lo_t [DEPTH], m_hi_t [DEPTH];
  logic [H-1:0]    m_lo_d [DEPTH], m_hi_d [DEPTH];
  logic            m_qv;
  logic [TAGW-1:0] m_qta, m_qtb;
  logic [H-1:0]    m_qha, m_qhb;
  logic            m_wbv, m_wbl;
  logic [TAGW-1:0] m_wbt;
  logic [W-1:0]    m_wbd;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [H-1:0] lo_pick(input logic [TAGW-1:0] t, input logic [H-1:0] dflt);
    logic [H-1:0] v = dflt;
    for (int i = DEPTH-1; i >= 0; i--) if (m_lo_v[i] && m_lo_t[i] == t) v = m_lo_d[i];
    if (res_lo_valid && res_lo_tag == t) v = res_lo_data;
    return v;
  endfunction

  function automatic logic [H-1:0] hi_pick(input logic [TAGW-1:0] t, input logic [H-1:0] dflt);
    logic [H-1:0] v = dflt;
    for (int i = DEPTH-1; i >= 0; i--) if (m_hi_v[i] && m_hi_t[i] == t) v = m_hi_d[i];
    if (res_hi_valid && res_hi_tag == t) v = res_hi_data;
    return v;
  endfunction

  task automatic idle();
    req_valid = 0; a_sel_lat = 0; b_sel_lat = 0;
    req_a_tag = 0; req_b_tag = 0;
    rf_a_data = 0; rf_b_data = 0; lat_data = 0;
    res_lo_valid = 0; res_lo_tag = 0; res_lo_data = 0; res_lo_to_lat = 0;
    res_hi_valid = 0; res_hi_tag = 0; res_hi_data = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_lo_v[i] = 0; m_lo_r[i] = 0; m_hi_v[i] = 0;
      m_lo_t[i] = 0; m_hi_t[i] = 0; m_lo_d[i] = 0; m_hi_d[i] = 0;
    end
    m_qv = 0; m_qta = 0; m_qtb = 0; m_qha = 0; m_qhb = 0;
    m_wbv = 0; m_wbl = 0; m_wbt = 0; m_wbd = 0;
  endtask

  task automatic cycle();
    logic [W-1:0] ea, eb;
    logic pair;
    #1;
    ea = a_sel_lat ? lat_data : rf_a_data;
    eb = b_sel_lat ? lat_data : rf_b_data;
    chk(op_a_lo == lo_pick(req_a_tag, ea[H-1:0]), lbl_lo, op_a_lo, lo_pick(req_a_tag, ea[H-1:0]));
    chk(op_b_lo == lo_pick(req_b_tag, eb[H-1:0]), lbl_lo, op_b_lo, lo_pick(req_b_tag, eb[H-1:0]));
    chk(op_hi_valid == m_qv, "R3", op_hi_valid, m_qv);
    if (m_qv) begin
      chk(op_a_hi == hi_pick(m_qta, m_qha), lbl_hi, op_a_hi, hi_pick(m_qta, m_qha));
      chk(op_b_hi == hi_pick(m_qtb, m_qhb), lbl_hi, op_b_hi, hi_pick(m_qtb, m_qhb));
    end
    chk(wb_valid == m_wbv, m_wbv ? "R6" : "R7", wb_valid, m_wbv);
    if (m_wbv && wb_valid) begin
      chk(wb_tag == m_wbt, "R6", wb_tag, m_wbt);
      chk(wb_data == m_wbd, "R6", wb_data, m_wbd);
      chk(wb_to_lat == m_wbl, "R8", wb_to_lat, m_wbl);
    end
    pair = res_hi_valid && m_lo_v[0] && m_lo_t[0] == res_hi_tag;
    @(posedge clk);
    m_wbv = pair; m_wbt = res_hi_tag; m_wbd = {res_hi_data, m_lo_d[0]}; m_wbl = m_lo_r[0];
    m_qv = req_valid; m_qta = req_a_tag; m_qtb = req_b_tag; m_qha = ea[W-1:H]; m_qhb = eb[W-1:H];
    for (int i = DEPTH-1; i >= 1; i--) begin
      m_lo_v[i] = m_lo_v[i-1]; m_lo_r[i] = m_lo_r[i-1]; m_lo_t[i] = m_lo_t[i-1]; m_lo_d[i] = m_lo_d[i-1];
      m_hi_v[i] = m_hi_v[i-1]; m_hi_t[i] = m_hi_t[i-1]; m_hi_d[i] = m_hi_d[i-1];
    end
    m_lo_v[0] = res_lo_valid; m_lo_r[0] = res_lo_to_lat; m_lo_t[0] = res_lo_tag; m_lo_d[0] = res_lo_data;
    m_hi_v[0] = res_hi_valid; m_hi_t[0] = res_hi_tag; m_hi_d[0] = res_hi_data;
    @(negedge clk);
  endtask

  task automatic flush();
    idle();
    repeat (DEPTH + 2) cycle();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TAGW-1:0] prev_lo;
    void'($urandom(32'd1234));
    idle();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(op_hi_valid == 0, "R9", op_hi_valid, 0);
    chk(wb_valid == 0, "R9", wb_valid, 0);
    @(negedge clk);

    lbl_lo = "R9"; lbl_hi = "R9";
    idle(); req_valid = 1; req_a_tag = 3; req_b_tag = 4;
    rf_a_data = 32'h1111_2222; rf_b_data = 32'h3333_4444;
    cycle();
    idle(); cycle();

    lbl_lo = "R2"; lbl_hi = "R2";
    idle(); req_valid = 1; req_a_tag = 7; req_b_tag = 8;
    a_sel_lat = 1; lat_data = 32'hCAFE_1234; rf_a_data = 32'h5555_6666; rf_b_data = 32'h7777_8888;
    cycle();
    idle(); cycle();

    lbl_lo = "R4"; lbl_hi = "R4";
    idle(); res_lo_valid = 1; res_lo_tag = 3; res_lo_data = 16'h0001; cycle();
    idle(); res_lo_valid = 1; res_lo_tag = 3; res_lo_data = 16'h0002;
    res_hi_valid = 1; res_hi_tag = 3; res_hi_data = 16'hA001; cycle();
    idle(); res_lo_valid = 1; res_lo_tag = 3; res_lo_data = 16'h0003;
    res_hi_valid = 1; res_hi_tag = 3; res_hi_data = 16'hA002;
    req_valid = 1; req_a_tag = 3; req_b_tag = 3; rf_a_data = 32'hDEAD_BEEF; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 3; res_hi_data = 16'hA003;
    req_valid = 1; req_a_tag = 3; req_b_tag = 5; cycle();
    idle(); cycle();

    flush();
    lbl_lo = "R5"; lbl_hi = "R5";
    idle(); res_lo_valid = 1; res_lo_tag = 9; res_lo_data = 16'h9999; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 9; res_hi_data = 16'h8888; cycle();
    idle(); repeat (DEPTH - 2) cycle();
    idle(); req_valid = 1; req_a_tag = 9; rf_a_data = 32'h0123_4567; cycle();
    idle(); req_valid = 1; req_a_tag = 9; rf_a_data = 32'h89AB_CDEF; cycle();
    idle(); req_valid = 1; req_a_tag = 9; rf_a_data = 32'h0F0F_F0F0; cycle();
    idle(); cycle();

    flush();
    lbl_lo = "R7"; lbl_hi = "R7";
    idle(); res_hi_valid = 1; res_hi_tag = 2; res_hi_data = 16'h4444; cycle();
    idle(); res_lo_valid = 1; res_lo_tag = 6; res_lo_data = 16'h1212; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 5; res_hi_data = 16'h3434; cycle();
    idle(); cycle();

    lbl_lo = "R6"; lbl_hi = "R8";
    idle(); req_valid = 1; req_a_tag = 1; req_b_tag = 2;
    rf_a_data = 32'h0000_0010; rf_b_data = 32'h0000_0020; cycle();
    idle(); res_lo_valid = 1; res_lo_tag = 2; res_lo_data = 16'h0030; res_lo_to_lat = 1;
    req_valid = 1; req_a_tag = 2; req_b_tag = 3; rf_b_data = 32'h0001_0000; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 2; res_hi_data = 16'h0000;
    res_lo_valid = 1; res_lo_tag = 3; res_lo_data = 16'h0031;
    req_valid = 1; req_a_tag = 3; req_b_tag = 4; rf_b_data = 32'h0000_0001; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 3; res_hi_data = 16'h0001;
    res_lo_valid = 1; res_lo_tag = 3; res_lo_data = 16'h0030; cycle();
    idle(); res_hi_valid = 1; res_hi_tag = 3; res_hi_data = 16'h0001; cycle();
    idle(); cycle();
    idle(); cycle();

    lbl_lo = "R1"; lbl_hi = "R3";
    prev_lo = 0;
    for (int k = 0; k < 600; k++) begin
      idle();
      req_valid = ($urandom % 4) != 0;
      req_a_tag = TAGW'($urandom % 4);
      req_b_tag = TAGW'($urandom % 4);
      rf_a_data = $urandom; rf_b_data = $urandom; lat_data = $urandom;
      a_sel_lat = ($urandom % 3) == 0; b_sel_lat = ($urandom % 3) == 0;
      res_lo_valid = ($urandom % 4) != 0;
      res_lo_tag = TAGW'($urandom % 4);
      res_lo_data = H'($urandom);
      res_lo_to_lat = $urandom % 2;
      res_hi_valid = ($urandom % 4) != 0;
      res_hi_tag = (($urandom % 4) != 0) ? prev_lo : TAGW'($urandom % 4);
      res_hi_data = H'($urandom);
      prev_lo = res_lo_tag;
      cycle();
    end
    idle(); cycle(); cycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule